// File: doc/BRIEF.md
# Trigger-Port Function Unit

This block is a single function unit for a processor whose program moves data between units instead of naming operations. It has two write ports and one read port. The operand port only stores a value. The trigger port takes a data word and an opcode, and a write to it starts the selected operation. The operation combines the stored operand with the trigger data. The result lands on the output port after a fixed latency that depends on the operation.

The unit does not interlock. The output port always shows the most recently completed result. Reading it before a result is due returns whatever the port held before. After reset the port shows zero, which software must treat as undefined. A completed operation overwrites the port without regard to whether the previous value was read, so the program must schedule its reads. Triggers may arrive every cycle. The logic operations and add and subtract complete in one cycle, and multiply completes in `MUL_LAT` cycles.

Top module: `tport_fu`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, the result port reads zero.
- R2: A write to the operand port alone never changes the result port. The stored value is used by later triggers.
- R3: A trigger uses the operand value stored before its own cycle. An operand write in the same cycle as a trigger affects only later triggers.
- R4: Opcodes 0 to 4 (0 = operand + trigger, 1 = operand − trigger, 2 = AND, 3 = OR, 4 = XOR, all modulo 2^W) show their result on the port in the cycle after the trigger.
- R5: Opcode 5 multiplies operand by trigger and keeps the low W bits. The result is visible in cycle t+MUL_LAT after a trigger in cycle t. Cycles t+1 to t+MUL_LAT−1 still show the earlier value.
- R6: A trigger is accepted every cycle. Back-to-back operations of either latency each produce their own result, in trigger order.
- R7: A one-cycle operation can complete in the same cycle as an earlier multiply. In that case the one-cycle result is written, and the multiply result never appears.
- R8: With no completion due, the result port keeps its value indefinitely. The next completion replaces it.
- R9: Opcodes 6 and 7 start nothing: the result port is unchanged then and in the following MUL_LAT cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| opnd_we | input | 1 | Write strobe for the operand port |
| opnd_data | input | W | Value stored on an operand write |
| trig_we | input | 1 | Write strobe for the trigger port; starts an operation |
| trig_op | input | 3 | Opcode carried with the trigger write |
| trig_data | input | W | Second operand carried with the trigger write |
| result | output | W | Result port; last completed value |

## Verification
A wrong operand latch shows on the very next one-cycle result, so each operand write is followed by a trigger whose sum or difference exposes it. A stage missing from the multiply pipeline, or an extra one, moves the product one cycle earlier or later. The bench therefore samples the port in every cycle between trigger and completion rather than only at the end. A wrong merge priority shows only when a multiply and a later one-cycle operation finish together, so that overlap is driven on purpose. The cycle after it is also checked, because the losing product must never surface.

// File: rtl/tport_fu_pkg.sv
`timescale 1ns/1ps
package tport_fu_pkg;

    localparam int OP_W = 3;

    // Opcode carried on the trigger port
    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_AND  = 3'd2,
        OP_OR   = 3'd3,
        OP_XOR  = 3'd4,
        OP_MUL  = 3'd5,
        OP_RSV6 = 3'd6,
        OP_RSV7 = 3'd7
    } fu_op_e;

endpackage

// File: rtl/tport_fu_alu.sv
`timescale 1ns/1ps
// Single-cycle operations: combinational result plus a flag that says
// the opcode belongs to this path.
module tport_fu_alu
    import tport_fu_pkg::*;
#(
    parameter int W = 32
) (
    input  fu_op_e         op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [W-1:0]   y,
    output logic           fast
);

    always_comb begin
        fast = 1'b1;
        case (op)
            OP_ADD:  y = a + b;
            OP_SUB:  y = a - b;
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_XOR:  y = a ^ b;
            default: begin
                y    = '0;
                fast = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/tport_fu_mulpipe.sv
`timescale 1ns/1ps
// Multiply path: product formed at the trigger, then carried through
// LAT-1 register stages with a valid bit per stage. Data registers load
// only when their valid input is set.
module tport_fu_mulpipe #(
    parameter int W   = 32,
    parameter int LAT = 3      // must be 2 or more
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic           done,
    output logic [W-1:0]   prod
);

    localparam int NSTG = LAT - 1;

    typedef struct packed {
        logic [NSTG-1:0]         vld;
        logic [NSTG-1:0][W-1:0]  val;
    } mstate_t;

    mstate_t      st_d, st_q;
    logic [W-1:0] prod_lo;

    always_comb begin
        prod_lo   = a * b;
        st_d      = st_q;
        st_d.vld[0] = start;
        if (start) begin
            st_d.val[0] = prod_lo;
        end
        for (int i = 1; i < NSTG; i++) begin
            st_d.vld[i] = st_q.vld[i-1];
            if (st_q.vld[i-1]) begin
                st_d.val[i] = st_q.val[i-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign done = st_q.vld[NSTG-1];
    assign prod = st_q.val[NSTG-1];

endmodule

// File: rtl/tport_fu_resport.sv
`timescale 1ns/1ps
// Result port register. A fresh one-cycle result was triggered later than
// any multiply finishing in the same cycle, so it takes the port.
module tport_fu_resport #(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           fast_we,
    input  logic [W-1:0]   fast_val,
    input  logic           slow_we,
    input  logic [W-1:0]   slow_val,
    output logic [W-1:0]   res
);

    typedef struct packed {
        logic [W-1:0] res;
    } rstate_t;

    rstate_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (fast_we) begin
            st_d.res = fast_val;
        end else if (slow_we) begin
            st_d.res = slow_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res = st_q.res;

endmodule

// File: rtl/tport_fu.sv
`timescale 1ns/1ps
// Function unit with an operand port, an opcode-carrying trigger port and
// an unprotected result port.
module tport_fu
    import tport_fu_pkg::*;
#(
    parameter int W       = 32,
    parameter int MUL_LAT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              opnd_we,
    input  logic [W-1:0]      opnd_data,
    input  logic              trig_we,
    input  logic [OP_W-1:0]   trig_op,
    input  logic [W-1:0]      trig_data,
    output logic [W-1:0]      result
);

    typedef struct packed {
        logic [W-1:0] opnd;
    } ustate_t;

    ustate_t      st_d, st_q;
    fu_op_e       op;
    logic [W-1:0] alu_y;
    logic         alu_fast;
    logic         fast_we;
    logic         mul_start;
    logic         mul_done;
    logic [W-1:0] mul_prod;

    // Operand latch: the trigger in this cycle sees st_q, not the new write
    always_comb begin
        st_d = st_q;
        if (opnd_we) begin
            st_d.opnd = opnd_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign op        = fu_op_e'(trig_op);
    assign fast_we   = trig_we & alu_fast;
    assign mul_start = trig_we & (op == OP_MUL);

    tport_fu_alu #(.W(W)) u_alu (
        .op   (op),
        .a    (st_q.opnd),
        .b    (trig_data),
        .y    (alu_y),
        .fast (alu_fast)
    );

    tport_fu_mulpipe #(.W(W), .LAT(MUL_LAT)) u_mul (
        .clk   (clk),
        .rst_n (rst_n),
        .start (mul_start),
        .a     (st_q.opnd),
        .b     (trig_data),
        .done  (mul_done),
        .prod  (mul_prod)
    );

    tport_fu_resport #(.W(W)) u_res (
        .clk      (clk),
        .rst_n    (rst_n),
        .fast_we  (fast_we),
        .fast_val (alu_y),
        .slow_we  (mul_done),
        .slow_val (mul_prod),
        .res      (result)
    );

endmodule

// File: rtl/tport_fu_chk.sv
`timescale 1ns/1ps
// Port-level checker: keeps its own shadow of the operand and of pending
// multiplies, built from the port traffic only.
module tport_fu_chk
    import tport_fu_pkg::*;
#(
    parameter int W       = 32,
    parameter int MUL_LAT = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              opnd_we,
    input logic [W-1:0]      opnd_data,
    input logic              trig_we,
    input logic [OP_W-1:0]   trig_op,
    input logic [W-1:0]      trig_data,
    input logic [W-1:0]      result
);

    localparam int NP = MUL_LAT - 1;

    logic [W-1:0]         sh_opnd;
    logic [NP-1:0]        sh_due;
    logic [NP-1:0][W-1:0] sh_prod;
    logic                 c_fast;
    logic                 c_mul;
    logic                 c_bad;
    logic                 c_due;
    logic [W-1:0]         c_exp;

    assign c_fast = trig_we && (trig_op <= 3'd4);
    assign c_mul  = trig_we && (trig_op == 3'd5);
    assign c_bad  = trig_we && (trig_op >= 3'd6);
    assign c_due  = sh_due[NP-1];

    always_comb begin
        case (trig_op)
            3'd0:    c_exp = sh_opnd + trig_data;
            3'd1:    c_exp = sh_opnd - trig_data;
            3'd2:    c_exp = sh_opnd & trig_data;
            3'd3:    c_exp = sh_opnd | trig_data;
            default: c_exp = sh_opnd ^ trig_data;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_opnd <= '0;
            sh_due  <= '0;
            sh_prod <= '0;
        end else begin
            if (opnd_we) sh_opnd <= opnd_data;
            sh_due[0]  <= c_mul;
            sh_prod[0] <= sh_opnd * trig_data;
            for (int i = 1; i < NP; i++) begin
                sh_due[i]  <= sh_due[i-1];
                sh_prod[i] <= sh_prod[i-1];
            end
        end
    end

    AST_RESET_ZERO: assert property (@(posedge clk) !rst_n |=> result == '0); // R1

    AST_OPND_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        opnd_we && !trig_we && !c_due |=> $stable(result)); // R2

    AST_FAST_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        c_fast |=> result == $past(c_exp)); // R4

    AST_MUL_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        c_due && !c_fast |=> result == $past(sh_prod[NP-1])); // R5

    AST_FAST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        c_fast && c_due |=> result == $past(c_exp)); // R7

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !c_fast && !c_due |=> $stable(result)); // R8

    AST_RSV_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        c_bad && !c_due |=> $stable(result)); // R9

endmodule

bind tport_fu tport_fu_chk #(.W(W), .MUL_LAT(MUL_LAT)) u_chk (.*);

// File: tb/sim_tport_fu.sv
`timescale 1ns/1ps
module sim_tport_fu;

    localparam int W       = 32;
    localparam int MUL_LAT = 3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         opnd_we = 1'b0;
    logic [W-1:0] opnd_data = '0;
    logic         trig_we = 1'b0;
    logic [2:0]   trig_op = '0;
    logic [W-1:0] trig_data = '0;
    logic [W-1:0] result;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    tport_fu #(.W(W), .MUL_LAT(MUL_LAT)) u0 (
        .clk(clk), .rst_n(rst_n),
        .opnd_we(opnd_we), .opnd_data(opnd_data),
        .trig_we(trig_we), .trig_op(trig_op), .trig_data(trig_data),
        .result(result)
    );

    task automatic check(input string req, input logic [W-1:0] exp);
        n_chk++;
        if (result !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, result, exp, $time);
        end
    endtask

    // Present one cycle of port writes at a falling edge; return at the
    // next falling edge with the strobes cleared.
    task automatic drive(input logic ow, input logic [W-1:0] od,
                         input logic tw, input logic [2:0] op,
                         input logic [W-1:0] td);
        opnd_we = ow; opnd_data = od;
        trig_we = tw; trig_op = op; trig_data = td;
        @(negedge clk);
        opnd_we = 1'b0; trig_we = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [W-1:0] ref_op(input logic [2:0] op,
                                            input logic [W-1:0] a, b);
        case (op)
            3'd0:    return a + b;
            3'd1:    return a - b;
            3'd2:    return a & b;
            3'd3:    return a | b;
            3'd4:    return a ^ b;
            default: return a * b;
        endcase
    endfunction

    task automatic t_reset();
        check("R1 reset value", '0);
    endtask

    task automatic t_opnd_only();
        drive(1, 32'h0000_1234, 0, 3'd0, '0);
        check("R2 operand write alone", '0);
        idle(3);
        check("R2 operand write alone, later", '0);
        drive(0, '0, 1, 3'd0, 32'h11);
        check("R3 stored operand used", 32'h0000_1245);
    endtask

    task automatic t_alu_ops();
        logic [W-1:0] a = 32'hF0F0_1234;
        logic [W-1:0] b = 32'h0FF0_FFFF;
        drive(1, a, 0, 3'd0, '0);
        for (int op = 0; op < 5; op++) begin
            drive(0, '0, 1, 3'(op), b);
            check($sformatf("R4 opcode %0d", op), ref_op(3'(op), a, b));
        end
        drive(1, 32'd1, 0, 3'd0, '0);
        drive(0, '0, 1, 3'd1, 32'd2);
        check("R4 subtract wraps", 32'hFFFF_FFFF);
        drive(0, '0, 1, 3'd0, 32'hFFFF_FFFF);
        check("R4 add wraps", 32'h0000_0000);
    endtask

    task automatic t_same_cycle();
        drive(1, 32'd10, 0, 3'd0, '0);
        drive(1, 32'd99, 1, 3'd0, 32'd1);
        check("R3 same-cycle write not seen", 32'd11);
        drive(0, '0, 1, 3'd0, 32'd1);
        check("R3 same-cycle write seen later", 32'd100);
    endtask

    task automatic t_mul();
        logic [W-1:0] prev;
        drive(1, 32'd6, 0, 3'd0, '0);
        prev = result;
        drive(0, '0, 1, 3'd5, 32'd7);
        for (int k = 1; k < MUL_LAT; k++) begin
            check($sformatf("R5 early read cycle +%0d", k), prev);
            idle(1);
        end
        check("R5 product lands", 32'd42);
        drive(1, 32'h0001_0001, 0, 3'd0, '0);
        drive(0, '0, 1, 3'd5, 32'h0001_0001);
        idle(MUL_LAT - 1);
        check("R5 product truncated", 32'h0002_0001);
    endtask

    task automatic t_pipeline();
        drive(1, 32'd3, 0, 3'd0, '0);
        drive(0, '0, 1, 3'd5, 32'd4);
        drive(0, '0, 1, 3'd5, 32'd5);
        drive(0, '0, 1, 3'd5, 32'd6);
        check("R6 first of three products", 32'd12);
        idle(1);
        check("R6 second of three products", 32'd15);
        idle(1);
        check("R6 third of three products", 32'd18);
        drive(0, '0, 1, 3'd0, 32'd1);
        check("R6 back-to-back add 1", 32'd4);
        drive(0, '0, 1, 3'd0, 32'd2);
        check("R6 back-to-back add 2", 32'd5);
        drive(0, '0, 1, 3'd1, 32'd10);
        check("R6 back-to-back sub", 32'hFFFF_FFF9);
    endtask

    task automatic t_collide();
        logic [W-1:0] prev = result;
        drive(0, '0, 1, 3'd5, 32'd5);
        check("R7 before overlap", prev);
        idle(1);
        check("R7 before overlap, second", prev);
        drive(0, '0, 1, 3'd0, 32'd1);
        check("R7 later short op wins", 32'd4);
        idle(1);
        check("R7 product never appears", 32'd4);
    endtask

    task automatic t_hold();
        drive(0, '0, 1, 3'd4, 32'hFF);
        check("R8 xor result", 32'h0000_00FC);
        idle(20);
        check("R8 held while idle", 32'h0000_00FC);
        drive(0, '0, 1, 3'd5, 32'd5);
        idle(MUL_LAT - 1);
        check("R8 product replaces held value", 32'd15);
        drive(0, '0, 1, 3'd0, 32'd0);
        check("R8 next completion overwrites", 32'd3);
    endtask

    task automatic t_bad_op();
        drive(1, 32'h50, 1, 3'd6, 32'd7);
        check("R9 opcode 6 no effect", 32'd3);
        drive(0, '0, 1, 3'd7, 32'd9);
        check("R9 opcode 7 no effect", 32'd3);
        idle(MUL_LAT);
        check("R9 nothing completes later", 32'd3);
        drive(0, '0, 1, 3'd0, 32'd1);
        check("R9 operand stored in reserved cycle", 32'h51);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 during reset", '0);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_opnd_only();
        t_alu_ops();
        t_same_cycle();
        t_mul();
        t_pipeline();
        t_collide();
        t_hold();
        t_bad_op();
        finished = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL all requirements: actual=hung expected=finished (watchdog)");
            summary();
            $finish;
        end
    end

endmodule